// File: doc/BRIEF.md
# Register-Subtract Micro-Step Sequencer

This block is a small accumulator datapath driven by a hard-wired micro-step controller. It computes "accumulator minus source register" for one of several source registers. The datapath has a source register file, a holding latch X in front of the ALU, an add/subtract ALU, a result latch Y that can drive the internal bus, and the accumulator A. Every transfer happens through explicit control lines. Register enables and latch strobes are active low. A latch takes its data when its strobe returns from 0 to 1, so each load uses two micro-steps.

A one-cycle `start` pulse with a register index in `reg_idx` launches a fixed ten-step sequence that advances one step per clock. The same order is used for every register. The sequence drives the following lines in turn:

1. The selected register enable.
2. The X strobe.
3. The subtract select.
4. The Y strobe.
5. The Y output enable.
6. The accumulator strobe.

A single-cycle `done` pulse follows the last step, and the controller then goes back to idle. Source registers and the accumulator can be preloaded through write ports, which are accepted only while the controller is idle.

Top module: `regsub_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator to zero and returns the controller to idle. In idle, `busy` and `done` are 0, every `enx_n` bit is 1, `x_stb_n`, `y_stb_n`, `y_oe_n` and `a_stb_n` are 1, and `alu_sub` is 0.
- R2: `start` sampled high at an edge while idle makes `busy` high from the next cycle. Steps 1 to 10 then occupy ten consecutive cycles. `done` is high for exactly one cycle, the eleventh cycle after the start edge, and idle follows with `busy` low.
- R3: `enx_n` bit k, with k the `reg_idx` value sampled at start, is low in steps 1, 2 and 3 and high otherwise. All other `enx_n` bits stay high throughout.
- R4: `x_stb_n` is low only in step 2, `y_stb_n` only in step 5, and `a_stb_n` only in step 8. At most one strobe is low in any cycle.
- R5: `alu_sub` is 1 (subtract) in steps 4 to 10 and 0 (add) in every other cycle.
- R6: `y_oe_n` is low in steps 7, 8 and 9 and high otherwise.
- R7: In the `done` cycle, `acc_q` equals the accumulator value at start minus the selected register, modulo 2^WIDTH. For example, 0x00 − 0x01 gives 0xFF.
- R8: A `start` seen while `busy` is high is ignored. No extra sequence runs and no extra `done` pulse appears.
- R9: `src_wr` and `acc_wr` take effect at the next edge only while idle. While `busy` is high, both are ignored and leave the register file and the accumulator unchanged.
- R10: Changes of `reg_idx` after the start edge do not alter which enable line the running sequence drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a subtract sequence when idle |
| reg_idx | input | IDXW | Source register index, sampled at start |
| src_wr | input | 1 | Source register write strobe (idle only) |
| src_wr_idx | input | IDXW | Source register write index |
| src_wr_data | input | WIDTH | Source register write data |
| acc_wr | input | 1 | Accumulator preload strobe (idle only) |
| acc_wr_data | input | WIDTH | Accumulator preload data |
| acc_q | output | WIDTH | Accumulator contents |
| busy | output | 1 | Sequence or done cycle in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| enx_n | output | NREGS | Active-low source register enables |
| alu_sub | output | 1 | ALU function select, 1 = subtract |
| x_stb_n | output | 1 | X latch strobe, captures on 0-to-1 |
| y_stb_n | output | 1 | Y latch strobe, captures on 0-to-1 |
| y_oe_n | output | 1 | Active-low Y output enable onto the bus |
| a_stb_n | output | 1 | Accumulator strobe, captures on 0-to-1 |

## Verification
The bench builds the block with its default parameters, WIDTH = 8 and NREGS = 4. This width puts the modulo wrap within reach with small operands such as 0x00 − 0x01 and 0x1A − 0xFF, and it lets every one of the four enable lines be selected in turn. Each step's control outputs are compared against a table written independently of the RTL. One run holds `start` high into the sequence, changes `reg_idx`, and pulses both write ports during step 1. That run shows, through later results and enable patterns, that all of these disturbances are ignored.

// File: rtl/regsub_pkg.sv
package regsub_pkg;

  localparam int unsigned STEPW      = 4;
  localparam int unsigned LAST_STEP  = 10;

  // step numbers whose position in the sequence is behaviour
  localparam logic [STEPW-1:0] ST_SEL_LAST = 4'd3;
  localparam logic [STEPW-1:0] ST_X_LOW    = 4'd2;
  localparam logic [STEPW-1:0] ST_SUB_ON   = 4'd4;
  localparam logic [STEPW-1:0] ST_Y_LOW    = 4'd5;
  localparam logic [STEPW-1:0] ST_OE_ON    = 4'd7;
  localparam logic [STEPW-1:0] ST_A_LOW    = 4'd8;
  localparam logic [STEPW-1:0] ST_OE_LAST  = 4'd9;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;

  typedef struct packed {
    logic alu_sub;
    logic x_stb_n;
    logic y_stb_n;
    logic y_oe_n;
    logic a_stb_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{alu_sub: 1'b0, x_stb_n: 1'b1, y_stb_n: 1'b1,
                                y_oe_n: 1'b1, a_stb_n: 1'b1};

  // control levels for one running step
  function automatic ctl_t decode_step(logic [STEPW-1:0] step);
    ctl_t c;
    c         = CTL_IDLE;
    c.alu_sub = (step >= ST_SUB_ON);
    c.x_stb_n = (step != ST_X_LOW);
    c.y_stb_n = (step != ST_Y_LOW);
    c.a_stb_n = (step != ST_A_LOW);
    c.y_oe_n  = !((step >= ST_OE_ON) && (step <= ST_OE_LAST));
    return c;
  endfunction

  function automatic logic select_window(logic [STEPW-1:0] step);
    return (step != '0) && (step <= ST_SEL_LAST);
  endfunction

endpackage

// File: rtl/regsub_ctrl.sv
module regsub_ctrl
  import regsub_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDXW-1:0]  reg_idx,
  output logic [NREGS-1:0] enx_n,
  output ctl_t             ctl,
  output logic             busy,
  output logic             done
);

  phase_t           phase_q;
  logic [STEPW-1:0] step_q;
  logic [IDXW-1:0]  sel_q;
  logic             running;
  logic             launch;
  logic             last_step;

  assign running   = (phase_q == PH_RUN);
  assign launch    = (phase_q == PH_IDLE) && start;
  assign last_step = running && (step_q == STEPW'(LAST_STEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      sel_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (launch) begin
          phase_q <= PH_RUN;
          step_q  <= STEPW'(1);
          sel_q   <= reg_idx;
        end
        PH_RUN: begin
          if (last_step) begin
            phase_q <= PH_FIN;
            step_q  <= '0;
          end else begin
            step_q  <= step_q + STEPW'(1);
          end
        end
        PH_FIN:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_enx
    assign enx_n[i] = !(running && select_window(step_q) && (sel_q == IDXW'(i)));
  end

  assign ctl  = running ? decode_step(step_q) : CTL_IDLE;
  assign busy = (phase_q != PH_IDLE);
  assign done = (phase_q == PH_FIN);

endmodule

// File: rtl/regsub_srcfile.sv
module regsub_srcfile #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [NREGS-1:0] enx_n,
  output logic [WIDTH-1:0] drive
);

  logic [WIDTH-1:0] regs_q [NREGS];
  logic [WIDTH-1:0] part   [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDXW'(i))) regs_q[i] <= wr_data;
    end
    // an enabled register places its value on the shared bus
    assign part[i] = enx_n[i] ? '0 : regs_q[i];
  end

  always_comb begin
    drive = '0;
    for (int i = 0; i < NREGS; i++) drive = drive | part[i];
  end

endmodule

// File: rtl/regsub_datapath.sv
module regsub_datapath
  import regsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [WIDTH-1:0] src_drive,
  input  logic             acc_wr,
  input  logic [WIDTH-1:0] acc_wr_data,
  output logic [WIDTH-1:0] acc_q,
  output logic             x_cap,
  output logic             y_cap,
  output logic             a_cap
);

  function automatic logic [WIDTH-1:0] alu_eval(logic [WIDTH-1:0] lhs,
                                                logic [WIDTH-1:0] rhs,
                                                logic sub);
    return sub ? (lhs - rhs) : (lhs + rhs);
  endfunction

  logic [WIDTH-1:0] x_q, y_q, bus, alu_out;
  logic             x_prev, y_prev, a_prev;

  assign bus     = src_drive | (ctl.y_oe_n ? '0 : y_q);
  assign alu_out = alu_eval(acc_q, x_q, ctl.alu_sub);

  // a latch fires when its strobe has just come back high
  assign x_cap = ctl.x_stb_n && !x_prev;
  assign y_cap = ctl.y_stb_n && !y_prev;
  assign a_cap = ctl.a_stb_n && !a_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= 1'b1;
      y_prev <= 1'b1;
      a_prev <= 1'b1;
      x_q    <= '0;
      y_q    <= '0;
      acc_q  <= '0;
    end else begin
      x_prev <= ctl.x_stb_n;
      y_prev <= ctl.y_stb_n;
      a_prev <= ctl.a_stb_n;
      if (x_cap) x_q <= bus;
      if (y_cap) y_q <= alu_out;
      if (a_cap)       acc_q <= bus;
      else if (acc_wr) acc_q <= acc_wr_data;
    end
  end

endmodule

// File: rtl/regsub_sequencer.sv
module regsub_sequencer
  import regsub_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDXW-1:0]  reg_idx,
  input  logic             src_wr,
  input  logic [IDXW-1:0]  src_wr_idx,
  input  logic [WIDTH-1:0] src_wr_data,
  input  logic             acc_wr,
  input  logic [WIDTH-1:0] acc_wr_data,
  output logic [WIDTH-1:0] acc_q,
  output logic             busy,
  output logic             done,
  output logic [NREGS-1:0] enx_n,
  output logic             alu_sub,
  output logic             x_stb_n,
  output logic             y_stb_n,
  output logic             y_oe_n,
  output logic             a_stb_n
);

  ctl_t             ctl;
  logic [WIDTH-1:0] src_drive;
  logic             x_cap, y_cap, a_cap;
  logic             src_wr_ok, acc_wr_ok;

  assign src_wr_ok = src_wr && !busy;
  assign acc_wr_ok = acc_wr && !busy;

  regsub_ctrl #(.NREGS(NREGS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .reg_idx(reg_idx),
    .enx_n(enx_n), .ctl(ctl), .busy(busy), .done(done)
  );

  regsub_srcfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_src (
    .clk(clk), .wr_en(src_wr_ok), .wr_idx(src_wr_idx), .wr_data(src_wr_data),
    .enx_n(enx_n), .drive(src_drive)
  );

  regsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .src_drive(src_drive),
    .acc_wr(acc_wr_ok), .acc_wr_data(acc_wr_data), .acc_q(acc_q),
    .x_cap(x_cap), .y_cap(y_cap), .a_cap(a_cap)
  );

  assign alu_sub = ctl.alu_sub;
  assign x_stb_n = ctl.x_stb_n;
  assign y_stb_n = ctl.y_stb_n;
  assign y_oe_n  = ctl.y_oe_n;
  assign a_stb_n = ctl.a_stb_n;

endmodule

// File: rtl/regsub_checks.sv
module regsub_checks #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [NREGS-1:0] enx_n,
  input logic             alu_sub,
  input logic             x_stb_n,
  input logic             y_stb_n,
  input logic             y_oe_n,
  input logic             a_stb_n,
  input logic             acc_wr,
  input logic             a_cap,
  input logic [WIDTH-1:0] acc_q
);

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_one_source_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~enx_n));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({~x_stb_n, ~y_stb_n, ~a_stb_n}) <= 1);

  assert_x_load_adds_R5: assert property (@(posedge clk) disable iff (rst)
    !x_stb_n |-> !alu_sub);

  assert_y_drive_sub_R6: assert property (@(posedge clk) disable iff (rst)
    !y_oe_n |-> alu_sub);

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!a_cap && !(acc_wr && !busy)) |=> $stable(acc_q));

endmodule

bind regsub_sequencer regsub_checks #(.WIDTH(WIDTH), .NREGS(NREGS)) u_checks (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .enx_n(enx_n), .alu_sub(alu_sub), .x_stb_n(x_stb_n), .y_stb_n(y_stb_n),
  .y_oe_n(y_oe_n), .a_stb_n(a_stb_n), .acc_wr(acc_wr), .a_cap(a_cap),
  .acc_q(acc_q)
);

// File: tb/regsub_sequencer_test.sv
module regsub_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int NREGS = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [1:0]       reg_idx = '0;
  logic             src_wr = 1'b0;
  logic [1:0]       src_wr_idx = '0;
  logic [WIDTH-1:0] src_wr_data = '0;
  logic             acc_wr = 1'b0;
  logic [WIDTH-1:0] acc_wr_data = '0;
  logic [WIDTH-1:0] acc_q;
  logic             busy, done, alu_sub, x_stb_n, y_stb_n, y_oe_n, a_stb_n;
  logic [NREGS-1:0] enx_n;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model_r [NREGS];
  logic [WIDTH-1:0] model_acc;
  logic [WIDTH-1:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regsub_sequencer #(.WIDTH(WIDTH), .NREGS(NREGS)) uut (
    .clk(clk), .rst(rst), .start(start), .reg_idx(reg_idx),
    .src_wr(src_wr), .src_wr_idx(src_wr_idx), .src_wr_data(src_wr_data),
    .acc_wr(acc_wr), .acc_wr_data(acc_wr_data), .acc_q(acc_q),
    .busy(busy), .done(done), .enx_n(enx_n), .alu_sub(alu_sub),
    .x_stb_n(x_stb_n), .y_stb_n(y_stb_n), .y_oe_n(y_oe_n), .a_stb_n(a_stb_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected {enx_n, alu_sub, x_stb_n, y_stb_n, y_oe_n, a_stb_n} per step
  function automatic logic [8:0] ref_ctl(int s, int idx);
    logic [3:0] en;
    logic [4:0] c;
    en = 4'b1111;
    if (s >= 1 && s <= 3) en[idx] = 1'b0;
    c = 5'b01111;
    case (s)
      1, 3:     c = 5'b01111;
      2:        c = 5'b00111;
      4, 6, 10: c = 5'b11111;
      5:        c = 5'b11011;
      7, 9:     c = 5'b11101;
      8:        c = 5'b11100;
      default:  c = 5'b01111;
    endcase
    return {en, c};
  endfunction

  function automatic logic [8:0] sampled();
    return {enx_n, alu_sub, x_stb_n, y_stb_n, y_oe_n, a_stb_n};
  endfunction

  task automatic write_src(input int idx, input logic [WIDTH-1:0] v);
    src_wr = 1'b1; src_wr_idx = 2'(idx); src_wr_data = v;
    @(negedge clk);
    src_wr = 1'b0;
    model_r[idx] = v;
  endtask

  task automatic write_acc(input logic [WIDTH-1:0] v);
    acc_wr = 1'b1; acc_wr_data = v;
    @(negedge clk);
    acc_wr = 1'b0;
    model_acc = v;
  endtask

  // driver: pushes the expected result, then walks the ten steps
  task automatic run_sub(input int idx, input bit disturb);
    logic [WIDTH-1:0] e;
    e = model_acc - model_r[idx];
    expq.push_back(e);
    model_acc = e;
    reg_idx = 2'(idx);
    start = 1'b1;
    for (int s = 1; s <= 10; s++) begin
      @(negedge clk);
      // R3 R4 R5 R6 R10: control pattern of this step
      check(sampled() == ref_ctl(s, idx), $sformatf("R3/R4/R5/R6/R10 step %0d", s),
            32'(sampled()), 32'(ref_ctl(s, idx)));
      check(busy && !done, "R2 busy in step", {30'd0, busy, done}, 32'b10);
      if (s == 1) begin
        start = disturb;                // R8: start held into a running sequence
        if (disturb) begin
          reg_idx = 2'(idx ^ 3);        // R10: index change after launch
          src_wr = 1'b1; src_wr_idx = 2'd1; src_wr_data = 8'hEE;   // R9
          acc_wr = 1'b1; acc_wr_data = 8'h77;                      // R9
        end
      end else if (s == 2) begin
        start = 1'b0; src_wr = 1'b0; acc_wr = 1'b0;
      end
    end
    @(negedge clk);
    check(done == 1'b1, "R2 done in eleventh cycle", 32'(done), 32'd1);
    @(negedge clk);
    check(!done && !busy, "R2/R8 single done then idle", {30'd0, busy, done}, 32'd0);
  endtask

  // monitor: compares each done against the scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected done", 32'(acc_q), 32'd0);
      end else begin
        logic [WIDTH-1:0] e;
        e = expq.pop_front();
        check(acc_q == e, "R7 result at done", 32'(acc_q), 32'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_acc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(acc_q == 0, "R1 acc cleared", 32'(acc_q), 32'd0);
    check(!busy && !done, "R1 idle", {30'd0, busy, done}, 32'd0);
    check(sampled() == 9'b1111_01111, "R1 idle control levels", 32'(sampled()),
          32'h1EF);

    write_src(0, 8'h05);
    write_src(1, 8'h01);
    write_src(2, 8'h80);
    write_src(3, 8'hFF);
    write_acc(8'h20);
    check(acc_q == 8'h20, "R9 preload while idle", 32'(acc_q), 32'h20);

    run_sub(0, 1'b0);   // 0x20-0x05 = 0x1B
    run_sub(1, 1'b0);   // 0x1A
    run_sub(3, 1'b0);   // R7 wrap: 0x1A-0xFF = 0x1B
    write_acc(8'h00);
    run_sub(1, 1'b0);   // R7 wrap: 0x00-0x01 = 0xFF
    run_sub(2, 1'b0);   // 0x7F
    run_sub(0, 1'b1);   // disturbed: 0x7A, writes ignored
    check(acc_q == 8'h7A, "R9 acc write ignored while busy", 32'(acc_q), 32'h7A);
    run_sub(1, 1'b0);   // R9: R1 still 0x01 -> 0x79

    repeat (3) @(negedge clk);
    check(!done && !busy, "R8 no extra sequence", {30'd0, busy, done}, 32'd0);
    check(expq.size() == 0, "R2 every result delivered", 32'(expq.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule